// File: doc/BRIEF.md
# Paging control register flush controller

This block keeps the three control registers that govern address translation (the mode register, the table-base register and the extension register) together with the mask that applies the address-bit-20 gate. It sees every write to those registers on one select-and-strobe port. It decides whether the translation cache must be emptied, and how thoroughly. The decision depends on which paging-relevant bits really changed, and, for the table base, on whether paging is on at the time of the write.

A level input drives the bit-20 gate. When that level differs from the bit now held in the mask, the block rewrites the mask. It also asks the execution engine to leave the code it is running, and requests a full flush. The block also derives two hidden mode flags from the mode register: a protected-mode flag and a segment-base-add flag. All flush and exit requests are one-cycle pulses that appear in the cycle after their cause.

Top module: `pgctl_flush_ctrl`

## Requirements
- R1: After a synchronous reset the mode register reads 0x60000010, the table-base and extension registers read 0, the gate mask reads 0xFFFFFFFF, protected mode is 0, segment-add is 1, and no pulse output is high.
- R2: With `wr_en` high, `wr_sel` 0 loads the mode register, 1 loads the table base and 2 loads the extension register. The new value is visible in the next cycle and the other registers keep their values. Select value 3 changes no register and raises no pulse.
- R3: A mode-register write that changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) raises `flush_all` in the cycle after the write.
- R4: A mode-register write that changes none of bits 31, 16 and 0 raises no flush pulse, even when other bits change.
- R5: A table-base write raises `flush_nonglobal` in the next cycle only if bit 31 of the stored mode register is 1 when the write occurs. The value is stored in either case.
- R6: An extension-register write raises `flush_all` in the next cycle only if it changes bit 7, bit 5 or bit 4.
- R7: When `a20_level` differs from bit 20 of the gate mask, `exec_exit` and `flush_all` are high in the next cycle. In that same cycle the mask reads 0xFFEFFFFF with bit 20 equal to the new level.
- R8: When `a20_level` equals bit 20 of the gate mask, the mask does not change and no exit pulse is raised.
- R9: `mode_prot` always equals bit 0 of the mode register. `mode_segadd` is 1 whenever that bit is 0, and a write that sets bit 0 leaves `mode_segadd` unchanged.
- R10: When a full-flush cause and a non-global flush cause fall in the same cycle, only `flush_all` is raised.
- R11: Each pulse lasts one cycle. In a cycle with no new cause, all three pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Target: 0 mode, 1 table base, 2 extension, 3 none |
| wr_data | input | 32 | Value to write |
| a20_level | input | 1 | Requested level of the address-bit-20 gate |
| cr0 | output | 32 | Stored mode register |
| cr3 | output | 32 | Stored table-base register |
| cr4 | output | 32 | Stored extension register |
| a20_mask | output | 32 | Address mask for the bit-20 gate |
| mode_prot | output | 1 | Hidden protected-mode flag |
| mode_segadd | output | 1 | Hidden segment-base-add flag |
| flush_all | output | 1 | Full translation-cache flush pulse |
| flush_nonglobal | output | 1 | Flush pulse that keeps global entries |
| exec_exit | output | 1 | Request to leave the code now executing |

## Verification
Each result is due exactly one cycle after its stimulus: the stored register, the gate mask, the hidden flags and the pulses all update at the same edge that captures the strobe or the new gate level. The bench applies each stimulus at a falling edge and compares every output at the next falling edge against a model that it updates arithmetically. It then adds an idle cycle and expects all pulses to be low there. It sweeps every combination of the watched bits, plus extra toggles of unwatched bits, both paging states for table-base writes, gate toggles and repeats, and coincident causes.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_BASE = 2'd1,
    SEL_EXT  = 2'd2,
    SEL_NONE = 2'd3
  } ctl_sel_e;

  localparam int SLOT_MODE = 0;
  localparam int SLOT_BASE = 1;
  localparam int SLOT_EXT  = 2;
  localparam int NUM_SLOTS = 3;

  localparam int MODE_PG_BIT = 31;
  localparam int MODE_WP_BIT = 16;
  localparam int MODE_PE_BIT = 0;
  localparam int EXT_PGE_BIT = 7;
  localparam int EXT_PAE_BIT = 5;
  localparam int EXT_PSE_BIT = 4;
endpackage

// File: rtl/pgctl_ctrl_regs.sv
module pgctl_ctrl_regs
  import pgctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] MODE_RST = 32'h6000_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] ext_q,
  output logic              segadd_q,
  output logic              full_cause,
  output logic              ng_cause
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] MODE_WATCH =
    (ONE << MODE_PG_BIT) | (ONE << MODE_WP_BIT) | (ONE << MODE_PE_BIT);
  localparam logic [DATA_W-1:0] EXT_WATCH =
    (ONE << EXT_PGE_BIT) | (ONE << EXT_PAE_BIT) | (ONE << EXT_PSE_BIT);

  logic [DATA_W-1:0] slot_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_wr;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      localparam logic [DATA_W-1:0] RST_V = (g == SLOT_MODE) ? MODE_RST : '0;
      assign slot_wr[g] = wr_en && (wr_sel == 2'(g));
      always_ff @(posedge clk) begin
        if (rst) slot_q[g] <= RST_V;
        else if (slot_wr[g]) slot_q[g] <= wr_data;
      end
    end
  endgenerate

  assign mode_q = slot_q[SLOT_MODE];
  assign base_q = slot_q[SLOT_BASE];
  assign ext_q  = slot_q[SLOT_EXT];

  logic mode_hit, ext_hit;
  always_comb begin
    mode_hit   = slot_wr[SLOT_MODE] && (|((wr_data ^ slot_q[SLOT_MODE]) & MODE_WATCH));
    ext_hit    = slot_wr[SLOT_EXT] && (|((wr_data ^ slot_q[SLOT_EXT]) & EXT_WATCH));
    full_cause = mode_hit || ext_hit;
    ng_cause   = slot_wr[SLOT_BASE] && slot_q[SLOT_MODE][MODE_PG_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) segadd_q <= !MODE_RST[MODE_PE_BIT];
    else if (slot_wr[SLOT_MODE] && !wr_data[MODE_PE_BIT]) segadd_q <= 1'b1;
  end

  // R2
  sel_none_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(mode_q) && $stable(base_q) && $stable(ext_q)));

  // R5
  base_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_BASE) |=> (base_q == $past(wr_data)));

  // R9
  segadd_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q[MODE_PE_BIT] |-> segadd_q);
endmodule

// File: rtl/pgctl_a20_gate.sv
module pgctl_a20_gate #(
  parameter int DATA_W  = 32,
  parameter int A20_POS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a20_level,
  output logic [DATA_W-1:0] mask_q,
  output logic              toggle
);
  logic [DATA_W-1:0] mask_nx;

  always_comb begin
    toggle           = (a20_level != mask_q[A20_POS]);
    mask_nx          = '1;
    mask_nx[A20_POS] = a20_level;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else if (toggle) mask_q <= mask_nx;
  end

  // R7
  a20_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (a20_level != mask_q[A20_POS]) |=> (mask_q[A20_POS] == $past(a20_level)));

  // R8
  a20_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (a20_level == mask_q[A20_POS]) |=> $stable(mask_q));
endmodule

// File: rtl/pgctl_flush_out.sv
module pgctl_flush_out #(
  parameter int N_FULL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_FULL-1:0] full_src,
  input  logic              ng_src,
  input  logic              exit_src,
  output logic              flush_all,
  output logic              flush_ng,
  output logic              exit_q
);
  logic any_full;
  assign any_full = |full_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_all <= 1'b0;
      flush_ng  <= 1'b0;
      exit_q    <= 1'b0;
    end else begin
      flush_all <= any_full;
      flush_ng  <= ng_src && !any_full;
      exit_q    <= exit_src;
    end
  end

  // R10
  flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flush_all && flush_ng));
endmodule

// File: rtl/pgctl_flush_ctrl.sv
module pgctl_flush_ctrl
  import pgctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int A20_POS = 20,
  parameter logic [DATA_W-1:0] MODE_RST = 32'h6000_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              a20_level,
  output logic [DATA_W-1:0] cr0,
  output logic [DATA_W-1:0] cr3,
  output logic [DATA_W-1:0] cr4,
  output logic [DATA_W-1:0] a20_mask,
  output logic              mode_prot,
  output logic              mode_segadd,
  output logic              flush_all,
  output logic              flush_nonglobal,
  output logic              exec_exit
);
  localparam int N_FULL = 2;

  logic reg_full, reg_ng, a20_tog;

  pgctl_ctrl_regs #(.DATA_W(DATA_W), .MODE_RST(MODE_RST)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_q(cr0), .base_q(cr3), .ext_q(cr4), .segadd_q(mode_segadd),
    .full_cause(reg_full), .ng_cause(reg_ng)
  );

  pgctl_a20_gate #(.DATA_W(DATA_W), .A20_POS(A20_POS)) gate_i (
    .clk(clk), .rst(rst), .a20_level(a20_level), .mask_q(a20_mask), .toggle(a20_tog)
  );

  pgctl_flush_out #(.N_FULL(N_FULL)) pulse_i (
    .clk(clk), .rst(rst), .full_src({a20_tog, reg_full}), .ng_src(reg_ng),
    .exit_src(a20_tog), .flush_all(flush_all), .flush_ng(flush_nonglobal),
    .exit_q(exec_exit)
  );

  assign mode_prot = cr0[MODE_PE_BIT];

  // R7
  exit_full_chk: assert property (@(posedge clk) disable iff (rst)
    exec_exit |-> flush_all);

  // R5
  ng_origin_chk: assert property (@(posedge clk) disable iff (rst)
    flush_nonglobal |-> $past(wr_en && (wr_sel == SEL_BASE) && cr0[MODE_PG_BIT]));
endmodule

// File: tb/pgctl_flush_ctrl_tb.sv
module pgctl_flush_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        a20_level = 1'b1;
  logic [31:0] cr0, cr3, cr4, a20_mask;
  logic        mode_prot, mode_segadd, flush_all, flush_nonglobal, exec_exit;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_cr0 = 32'h6000_0010, m_cr3 = '0, m_cr4 = '0, m_mask = 32'hFFFF_FFFF;
  logic        m_seg = 1'b1;
  localparam logic [31:0] W0 = 32'h8001_0001;
  localparam logic [31:0] W4 = 32'h0000_00B0;

  always #5 clk = ~clk;

  pgctl_flush_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .a20_level(a20_level), .cr0(cr0), .cr3(cr3), .cr4(cr4), .a20_mask(a20_mask),
    .mode_prot(mode_prot), .mode_segadd(mode_segadd), .flush_all(flush_all),
    .flush_nonglobal(flush_nonglobal), .exec_exit(exec_exit)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic e_all, input logic e_ng,
                           input logic e_exit);
    chk("R2", "cr0", cr0, m_cr0);
    chk("R2", "cr3", cr3, m_cr3);
    chk("R2", "cr4", cr4, m_cr4);
    chk("R7", "a20_mask", a20_mask, m_mask);
    chk("R9", "mode_prot", 32'(mode_prot), 32'(m_cr0[0]));
    chk("R9", "mode_segadd", 32'(mode_segadd), 32'(m_seg));
    chk(tag, "flush_all", 32'(flush_all), 32'(e_all));
    chk(tag, "flush_nonglobal", 32'(flush_nonglobal), 32'(e_ng));
    chk(tag, "exec_exit", 32'(exec_exit), 32'(e_exit));
  endtask

  // Called at a falling edge; applies one stimulus and checks one cycle later.
  task automatic step(input logic en, input logic [1:0] sel, input logic [31:0] d,
                      input logic a20);
    logic e_all, e_ng, e_exit;
    int n_cause;
    string tag;
    e_all = 1'b0; e_ng = 1'b0; e_exit = 1'b0; n_cause = 0;
    tag = en ? "R2" : "R11";
    wr_en = en; wr_sel = sel; wr_data = d; a20_level = a20;
    if (en) begin
      case (sel)
        2'd0: begin
          if (((d ^ m_cr0) & W0) != 0) begin e_all = 1'b1; n_cause++; tag = "R3"; end
          else tag = "R4";
          m_cr0 = d;
          if (!d[0]) m_seg = 1'b1;
        end
        2'd1: begin
          tag = "R5";
          if (m_cr0[31]) begin e_ng = 1'b1; n_cause++; end
          m_cr3 = d;
        end
        2'd2: begin
          tag = "R6";
          if (((d ^ m_cr4) & W4) != 0) begin e_all = 1'b1; n_cause++; end
          m_cr4 = d;
        end
        default: tag = "R2";
      endcase
    end
    if (a20 != m_mask[20]) begin
      e_all = 1'b1; e_exit = 1'b1; n_cause++;
      m_mask = 32'hFFEF_FFFF | (32'(a20) << 20);
      if (!en) tag = "R7";
    end else if (!en) tag = "R8";
    if (n_cause > 1) tag = "R10";
    if (e_all) e_ng = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag, e_all, e_ng, e_exit);
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 32'h0, m_mask[20]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_all("R1", 1'b0, 1'b0, 1'b0);

    // R3 / R4: sweep the watched mode bits plus unwatched toggles
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      d = 32'h0000_0010;
      d[31] = i[0]; d[16] = i[1]; d[0] = i[2]; d[5] = i[3];
      step(1'b1, 2'd0, d, m_mask[20]);
      step(1'b1, 2'd0, d ^ 32'h0000_0020, m_mask[20]);
      step(1'b1, 2'd0, d ^ 32'h0000_0220, m_mask[20]);
      idle();
    end

    // R9: setting protection enable leaves segment-add unchanged
    step(1'b1, 2'd0, 32'h0000_0000, m_mask[20]);
    step(1'b1, 2'd0, 32'h0000_0001, m_mask[20]);
    idle();

    // R5: table-base writes with paging on and off
    for (int p = 0; p < 2; p++) begin
      step(1'b1, 2'd0, p[0] ? 32'h8000_0011 : 32'h0000_0011, m_mask[20]);
      for (int k = 0; k < 4; k++) begin
        step(1'b1, 2'd1, 32'h0012_3000 + 32'(k * 32'h1000) + 32'(p), m_mask[20]);
        if (k[0]) idle();
      end
      idle();
    end

    // R6: sweep the watched extension bits plus an unwatched one
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      d = '0;
      d[7] = i[0]; d[5] = i[1]; d[4] = i[2]; d[2] = i[3];
      step(1'b1, 2'd2, d, m_mask[20]);
      step(1'b1, 2'd2, d ^ 32'h0000_0004, m_mask[20]);
      idle();
    end

    // R2: select value 3 changes nothing
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 2'd3, 32'hDEAD_0000 ^ 32'(k), m_mask[20]);
    end
    idle();

    // R7 / R8: gate toggles and repeats
    step(1'b0, 2'd0, '0, 1'b0);
    step(1'b0, 2'd0, '0, 1'b0);
    step(1'b0, 2'd0, '0, 1'b1);
    step(1'b0, 2'd0, '0, 1'b1);
    step(1'b0, 2'd0, '0, 1'b0);
    idle();

    // R10: coincident causes
    step(1'b1, 2'd0, 32'h8000_0011, m_mask[20]);
    idle();
    step(1'b1, 2'd1, 32'h0055_5000, ~m_mask[20]);
    idle();
    step(1'b1, 2'd1, 32'h0066_6000, m_mask[20]);
    idle();
    step(1'b1, 2'd0, 32'h0001_0011, ~m_mask[20]);
    idle();

    // R1: reset restores the initial state mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cr0 = 32'h6000_0010; m_cr3 = '0; m_cr4 = '0; m_mask = 32'hFFFF_FFFF; m_seg = 1'b1;
    a20_level = 1'b1;
    check_all("R1", 1'b0, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule